// File: doc/BRIEF.md
# Local-Bus FIFO DMA Engine

This block moves 32-bit words between a bridge FIFO and memory or peripherals on a multiplexed address/data local bus. Software running on the local processor first writes a start address and then a byte count. Bit 24 of the count word selects the direction. Loading a non-zero count makes the engine request the bus with a hold line. Once the processor grants it, the engine runs burst cycles. Each burst has one address phase and up to four data phases. Every completed data phase moves one word through the FIFO and advances the address by 4. When the last word has moved, the engine releases the bus.

While the processor owns the bus, every shared line the engine can drive is released. The address/data enable and the control enable are low, so the pad logic outside can float the lines. Processor cycles to the register space, which is any address with A21 set, are acknowledged with a one-cycle ready pulse. The FIFO read side is first-word-fall-through: the word to send sits on `fifo_rdata_i`, and one read strobe advances it.

Top module: `dma_fifo_bus_eng`

## Requirements
- R1: A processor write with A21=1 and A20=1 loads the count word. Bits 23:2 give the number of words. Bits 1:0 are ignored. The count register resets to zero, and loading a zero word count causes no hold request and no bus activity.
- R2: Count bit 24 = 1 selects bus-to-FIFO. W/R# is driven low, bus data goes to `fifo_wdata_o`, and the write strobe fires. Bit 24 = 0 selects FIFO-to-bus. W/R# is driven high, `fifo_rdata_i` is driven on AD in data phases, and the read strobe fires.
- R3: Hold is asserted in the cycle after a non-zero count load. The engine drives no shared line until it has sampled the grant high, and it drives none while hold is low.
- R4: Each burst starts with a single-cycle ADS# phase carrying the current address. Data phase i of a transfer targets start+4·i, so each new burst starts 16 bytes above the previous one. The number of ADS# phases is ceil(words/4).
- R5: BLAST# is low in data phase i exactly when i mod 4 = 3 or i is the last phase of the transfer.
- R6: A data phase completes only at a clock edge where RDY_IN# is low. Wait cycles keep the address, the count and the phase unchanged and produce no FIFO strobe.
- R7: Every completed data phase produces exactly one active-low FIFO strobe, in the same cycle in which RDY_IN# is low. The two strobes are never active together.
- R8: All four byte enables are low in every address and data phase the engine drives.
- R9: The total number of completed data phases equals the loaded word count. Hold drops and the bus is released in the cycle after the final phase.
- R10: A processor ADS# with A21=1 while the engine is idle gives RDY_OUT# low for exactly the following cycle. AD in that cycle is taken as write data if W/R# was high at ADS#. A write with A21=1 and A20=0 sets the start address, with bits 1:0 forced to zero. Cycles with A21=0 get no acknowledge, and a read of the count register does not start a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_o | output | 1 | Bus request to the local processor |
| hlda_i | input | 1 | Bus grant from the local processor |
| ad_i | input | 32 | Address/data bus as seen from the pads |
| ad_o | output | 32 | Address/data value driven by the engine |
| ad_oe_o | output | 1 | Drive enable for `ad_o` |
| ads_n_i | input | 1 | Address strobe from a processor cycle |
| ads_n_o | output | 1 | Address strobe driven by the engine |
| wr_i | input | 1 | W/R# from a processor cycle (1 = write) |
| wr_o | output | 1 | W/R# driven by the engine (1 = write) |
| be_n_o | output | 4 | Byte enables, active low |
| blast_n_o | output | 1 | Last data phase of a burst, active low |
| ctl_oe_o | output | 1 | Drive enable for ADS#, W/R#, byte enables and BLAST# |
| rdy_in_n_i | input | 1 | Ready from the target for engine cycles, active low |
| rdy_out_n_o | output | 1 | Ready to the processor for register cycles, active low |
| rd_fifo_n_o | output | 1 | Pop one word from the FIFO, active low |
| wr_fifo_n_o | output | 1 | Push one word into the FIFO, active low |
| fifo_rdata_i | input | 32 | Head word of the FIFO |
| fifo_wdata_o | output | 32 | Word pushed into the FIFO |

## Verification
On every cycle the assertions check the bus ownership rules: drive only under hold, and first drive only after a sampled grant. They also check the one-cycle shape of ADS# and RDY_OUT#, that a burst after BLAST# is followed by a new ADS# or by bus release, that wait states leave the address and count untouched, and that the two FIFO strobes are exclusive. Other properties need whole transfers. These are the address sequence across bursts, the exact BLAST# positions, the word count and the data moved in each direction, and the effect of register decode corner cases such as ignored low count bits, zero counts, reads and unacknowledged addresses. Only the bench's scenarios, with random grant latency and random wait states, can show these.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

    localparam int DW     = 32;
    localparam int SEL_HI = 21;   // register space select
    localparam int SEL_LO = 20;   // 1 = count word, 0 = start address

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_REQ,
        ENG_ADDR,
        ENG_DATA
    } eng_state_e;

    typedef struct packed {
        logic          cnt_ld;
        logic          adr_ld;
        logic [DW-1:0] data;
    } cpu_wr_t;

    typedef struct packed {
        logic hold;
        logic ctrl_oe;
        logic ad_oe;
        logic ads_n;
        logic wr;
        logic blast_n;
    } bus_ctl_t;

    function automatic logic [DW-1:0] word_align(input logic [DW-1:0] a);
        return {a[DW-1:2], 2'b00};
    endfunction

endpackage

// File: rtl/dma_cpu_port.sv
module dma_cpu_port
    import dma_eng_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          ads_n_i,
    input  logic          wr_i,
    input  logic [DW-1:0] ad_i,
    output logic          rdy_out_n,
    output cpu_wr_t       cpu_wr
);

    logic pend_q;
    logic sel_cnt_q;
    logic write_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= 1'b0;
            sel_cnt_q <= 1'b0;
            write_q   <= 1'b0;
        end else begin
            pend_q <= en && !pend_q && !ads_n_i && ad_i[SEL_HI];
            if (!ads_n_i) begin
                sel_cnt_q <= ad_i[SEL_LO];
                write_q   <= wr_i;
            end
        end
    end

    assign rdy_out_n     = ~pend_q;
    assign cpu_wr.cnt_ld = pend_q && write_q && sel_cnt_q;
    assign cpu_wr.adr_ld = pend_q && write_q && !sel_cnt_q;
    assign cpu_wr.data   = ad_i;

    // R10: acknowledge lasts one cycle
    a_r10_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        !rdy_out_n |=> rdy_out_n);

    // R10: acknowledge only follows a register-space address strobe
    a_r10_ack_after_ads: assert property (@(posedge clk) disable iff (rst)
        !rdy_out_n |-> $past(!ads_n_i && ad_i[SEL_HI]));

endmodule

// File: rtl/dma_burst_ctrl.sv
module dma_burst_ctrl
    import dma_eng_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter int BURST_LEN = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  cpu_wr_t       cpu_wr,
    input  logic          hlda,
    input  logic          rdy_in_n,
    input  logic [DW-1:0] ad_i,
    input  logic [DW-1:0] fifo_rdata,
    output bus_ctl_t      ctl,
    output logic [DW-1:0] ad_o,
    output logic [3:0]    be_n,
    output logic          rd_fifo_n,
    output logic          wr_fifo_n,
    output logic [DW-1:0] fifo_wdata,
    output logic          idle
);

    localparam int WW       = CNT_W - 2;
    localparam int BW       = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [BW-1:0] BEAT_MAX = BW'(BURST_LEN - 1);
    localparam logic [WW-1:0] ONE_WORD = WW'(1);

    eng_state_e    st;
    logic [WW-1:0] words_left;
    logic [DW-1:0] addr;
    logic [BW-1:0] beat;
    logic          to_fifo;     // 1: bus reads into FIFO
    logic          last;
    logic          done;
    logic          unused_lo;

    assign unused_lo = ^cpu_wr.data[1:0];
    assign last = (beat == BEAT_MAX) || (words_left == ONE_WORD);
    assign done = (st == ENG_DATA) && !rdy_in_n;
    assign idle = (st == ENG_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ENG_IDLE;
            words_left <= '0;
            addr       <= '0;
            beat       <= '0;
            to_fifo    <= 1'b0;
        end else begin
            unique case (st)
                ENG_IDLE: begin
                    if (cpu_wr.adr_ld)
                        addr <= word_align(cpu_wr.data);
                    if (cpu_wr.cnt_ld) begin
                        words_left <= cpu_wr.data[CNT_W-1:2];
                        to_fifo    <= cpu_wr.data[CNT_W];
                        beat       <= '0;
                        if (|cpu_wr.data[CNT_W-1:2])
                            st <= ENG_REQ;
                    end
                end
                ENG_REQ:  if (hlda) st <= ENG_ADDR;
                ENG_ADDR: st <= ENG_DATA;
                ENG_DATA: begin
                    if (!rdy_in_n) begin
                        words_left <= words_left - ONE_WORD;
                        addr       <= addr + DW'(4);
                        if (last) begin
                            beat <= '0;
                            st   <= (words_left == ONE_WORD) ? ENG_IDLE : ENG_ADDR;
                        end else begin
                            beat <= beat + BW'(1);
                        end
                    end
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl  = '{hold: 1'b0, ctrl_oe: 1'b0, ad_oe: 1'b0,
                 ads_n: 1'b1, wr: 1'b1, blast_n: 1'b1};
        ad_o = '0;
        unique case (st)
            ENG_REQ: ctl.hold = 1'b1;
            ENG_ADDR: begin
                ctl.hold    = 1'b1;
                ctl.ctrl_oe = 1'b1;
                ctl.ad_oe   = 1'b1;
                ctl.ads_n   = 1'b0;
                ctl.wr      = ~to_fifo;
                ad_o        = addr;
            end
            ENG_DATA: begin
                ctl.hold    = 1'b1;
                ctl.ctrl_oe = 1'b1;
                ctl.ad_oe   = ~to_fifo;
                ctl.wr      = ~to_fifo;
                ctl.blast_n = ~last;
                ad_o        = to_fifo ? '0 : fifo_rdata;
            end
            default: ;
        endcase
    end

    assign be_n       = ctl.ctrl_oe ? 4'b0000 : 4'b1111;
    assign rd_fifo_n  = ~(done && !to_fifo);
    assign wr_fifo_n  = ~(done && to_fifo);
    assign fifo_wdata = ad_i;

    // R3: shared lines only while holding the bus
    a_r3_drive_under_hold: assert property (@(posedge clk) disable iff (rst)
        ctl.ctrl_oe |-> ctl.hold);

    // R3: first drive only after the grant was sampled
    a_r3_grant_before_drive: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.ctrl_oe) |-> $past(hlda));

    // R4: address phase is a single cycle followed by a data phase
    a_r4_ads_single: assert property (@(posedge clk) disable iff (rst)
        !ctl.ads_n |=> (ctl.ads_n && st == ENG_DATA));

    // R5: after the last phase of a burst comes a new address or release
    a_r5_blast_ends_burst: assert property (@(posedge clk) disable iff (rst)
        (done && !ctl.blast_n) |=> (!ctl.ads_n || !ctl.hold));

    // R6: wait states freeze the transfer state
    a_r6_wait_holds: assert property (@(posedge clk) disable iff (rst)
        (st == ENG_DATA && rdy_in_n) |=>
            (st == ENG_DATA && $stable(addr) && $stable(words_left)));

    // R7: the two FIFO strobes never coincide
    a_r7_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({~rd_fifo_n, ~wr_fifo_n}));

    // R9: each completed phase removes exactly one word
    a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
        done |=> (words_left == $past(words_left) - ONE_WORD));

    // R1: a zero word count never requests the bus
    a_r1_zero_no_hold: assert property (@(posedge clk) disable iff (rst)
        (idle && cpu_wr.cnt_ld && cpu_wr.data[CNT_W-1:2] == '0) |=> !ctl.hold);

endmodule

// File: rtl/dma_fifo_bus_eng.sv
module dma_fifo_bus_eng
    import dma_eng_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter int BURST_LEN = 4
) (
    input  logic          clk,
    input  logic          rst,
    output logic          hold_o,
    input  logic          hlda_i,
    input  logic [31:0]   ad_i,
    output logic [31:0]   ad_o,
    output logic          ad_oe_o,
    input  logic          ads_n_i,
    output logic          ads_n_o,
    input  logic          wr_i,
    output logic          wr_o,
    output logic [3:0]    be_n_o,
    output logic          blast_n_o,
    output logic          ctl_oe_o,
    input  logic          rdy_in_n_i,
    output logic          rdy_out_n_o,
    output logic          rd_fifo_n_o,
    output logic          wr_fifo_n_o,
    input  logic [31:0]   fifo_rdata_i,
    output logic [31:0]   fifo_wdata_o
);

    cpu_wr_t  cpu_wr;
    bus_ctl_t ctl;
    logic     eng_idle;

    dma_cpu_port u_cpu (
        .clk       (clk),
        .rst       (rst),
        .en        (eng_idle),
        .ads_n_i   (ads_n_i),
        .wr_i      (wr_i),
        .ad_i      (ad_i),
        .rdy_out_n (rdy_out_n_o),
        .cpu_wr    (cpu_wr)
    );

    dma_burst_ctrl #(
        .CNT_W     (CNT_W),
        .BURST_LEN (BURST_LEN)
    ) u_burst (
        .clk        (clk),
        .rst        (rst),
        .cpu_wr     (cpu_wr),
        .hlda       (hlda_i),
        .rdy_in_n   (rdy_in_n_i),
        .ad_i       (ad_i),
        .fifo_rdata (fifo_rdata_i),
        .ctl        (ctl),
        .ad_o       (ad_o),
        .be_n       (be_n_o),
        .rd_fifo_n  (rd_fifo_n_o),
        .wr_fifo_n  (wr_fifo_n_o),
        .fifo_wdata (fifo_wdata_o),
        .idle       (eng_idle)
    );

    assign hold_o    = ctl.hold;
    assign ad_oe_o   = ctl.ad_oe;
    assign ctl_oe_o  = ctl.ctrl_oe;
    assign ads_n_o   = ctl.ads_n;
    assign wr_o      = ctl.wr;
    assign blast_n_o = ctl.blast_n;

endmodule

// File: tb/dma_fifo_bus_eng_tb.sv
module dma_fifo_bus_eng_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hold_o, hlda_i = 1'b0;
    logic [31:0] ad_i, ad_o, fifo_rdata_i = '0, fifo_wdata_o;
    logic        ad_oe_o, ads_n_o, wr_o, blast_n_o, ctl_oe_o;
    logic        ads_n_i = 1'b1, wr_i = 1'b0;
    logic [3:0]  be_n_o;
    logic        rdy_in_n_i, rdy_out_n_o, rd_fifo_n_o, wr_fifo_n_o;

    logic [31:0] ad_cpu = '0, ad_tgt = '0;
    logic        tgt_drv = 1'b0, rdy_tgt = 1'b1;
    assign ad_i       = tgt_drv ? ad_tgt : ad_cpu;
    assign rdy_in_n_i = rdy_tgt;

    always #4 clk = ~clk;

    dma_fifo_bus_eng dut_i (.*);

    int errors = 0, checks = 0;
    logic [31:0] exp_start = '0;
    int          exp_words = 0, beat_idx = 0, ads_cnt = 0;
    bit          exp_dir = 1'b0, pend_end = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
        end
    endtask

    function automatic logic [31:0] fifo_word(input int i);
        return exp_start ^ 32'hF1F0_0000 ^ (i * 32'h0001_0103);
    endfunction

    function automatic logic [31:0] tgt_word(input logic [31:0] a);
        return a ^ 32'h5A5A_00C3;
    endfunction

    function automatic bit exp_blast(input int i, input int n);
        return (i % 4 == 3) || (i == n - 1);
    endfunction

    // target and arbiter model
    task automatic responder();
        forever begin
            @(negedge clk);
            tgt_drv = 1'b0;
            rdy_tgt = 1'b1;
            if (pend_end) begin
                chk(!hold_o && !ctl_oe_o && !ad_oe_o, "R9 release after last phase", {31'b0, hold_o}, 32'd0);
                pend_end = 1'b0;
            end
            if (!hlda_i)
                chk(!ctl_oe_o && !ad_oe_o, "R3 no drive without grant", {31'b0, ctl_oe_o}, 32'd0);
            if (ctl_oe_o && !ads_n_o) begin
                chk(beat_idx % 4 == 0, "R4 ADS at burst start", beat_idx, 32'd0);
                chk(ad_o == exp_start + 32'(4 * beat_idx), "R4 ADS address", ad_o, exp_start + 32'(4 * beat_idx));
                chk(wr_o == !exp_dir, "R2 W/R# level", {31'b0, wr_o}, {31'b0, !exp_dir});
                chk(be_n_o == 4'b0000, "R8 byte enables in address phase", {28'b0, be_n_o}, 32'd0);
                ads_cnt++;
            end else if (ctl_oe_o) begin
                logic [31:0] a;
                a = exp_start + 32'(4 * beat_idx);
                chk(be_n_o == 4'b0000, "R8 byte enables in data phase", {28'b0, be_n_o}, 32'd0);
                chk(ad_oe_o == !exp_dir, "R2 AD drive by direction", {31'b0, ad_oe_o}, {31'b0, !exp_dir});
                fifo_rdata_i = fifo_word(beat_idx);
                if (exp_dir) begin
                    tgt_drv = 1'b1;
                    ad_tgt  = tgt_word(a);
                end
                rdy_tgt = ($urandom % 5 < 3) ? 1'b0 : 1'b1;
                #1;
                if (!rdy_tgt) begin
                    chk(blast_n_o == !exp_blast(beat_idx, exp_words), "R5 BLAST# position",
                        {31'b0, blast_n_o}, {31'b0, !exp_blast(beat_idx, exp_words)});
                    if (exp_dir) begin
                        chk(!wr_fifo_n_o && rd_fifo_n_o, "R7 push strobe", {30'b0, wr_fifo_n_o, rd_fifo_n_o}, 32'd1);
                        chk(fifo_wdata_o == tgt_word(a), "R2 word into FIFO", fifo_wdata_o, tgt_word(a));
                    end else begin
                        chk(!rd_fifo_n_o && wr_fifo_n_o, "R7 pop strobe", {30'b0, wr_fifo_n_o, rd_fifo_n_o}, 32'd2);
                        chk(ad_o == fifo_word(beat_idx), "R2 word onto bus", ad_o, fifo_word(beat_idx));
                    end
                    if (beat_idx == exp_words - 1)
                        pend_end = 1'b1;
                    beat_idx++;
                end else begin
                    chk(rd_fifo_n_o && wr_fifo_n_o, "R6 no strobe in wait state",
                        {30'b0, wr_fifo_n_o, rd_fifo_n_o}, 32'd3);
                end
            end
            if (!hold_o)
                hlda_i = 1'b0;
            else if (!hlda_i && ($urandom % 3 == 0))
                hlda_i = 1'b1;
        end
    endtask

    task automatic cpu_cycle(input logic [1:0] sel, input logic [31:0] data, input bit wr);
        @(negedge clk);
        ad_cpu  = {10'b0, sel, 20'h0};
        ads_n_i = 1'b0;
        wr_i    = wr;
        @(negedge clk);
        chk(rdy_out_n_o == !sel[1], "R10 acknowledge decode", {31'b0, rdy_out_n_o}, {31'b0, !sel[1]});
        ads_n_i = 1'b1;
        ad_cpu  = data;
        @(negedge clk);
        chk(rdy_out_n_o, "R10 single-cycle acknowledge", {31'b0, rdy_out_n_o}, 32'd1);
        ad_cpu = '0;
    endtask

    task automatic expect_quiet(input string req);
        bit seen;
        seen = 1'b0;
        repeat (8) begin
            @(negedge clk);
            if (hold_o || ctl_oe_o || ad_oe_o) seen = 1'b1;
        end
        chk(!seen, req, {31'b0, seen}, 32'd0);
    endtask

    task automatic run_xfer(input logic [31:0] start, input logic [23:0] bytes, input bit dir);
        exp_start = {start[31:2], 2'b00};
        exp_words = int'(bytes[23:2]);
        exp_dir   = dir;
        beat_idx  = 0;
        ads_cnt   = 0;
        cpu_cycle(2'b10, start, 1'b1);
        cpu_cycle(2'b11, {7'b0, dir, bytes}, 1'b1);
        if (exp_words == 0) begin
            expect_quiet("R1 zero count stays idle");
        end else begin
            chk(hold_o, "R3 hold after count load", {31'b0, hold_o}, 32'd1);
            while (hold_o) @(negedge clk);
            chk(beat_idx == exp_words, "R9 phases equal word count", beat_idx, exp_words);
            chk(ads_cnt == (exp_words + 3) / 4, "R4 number of bursts", ads_cnt, (exp_words + 3) / 4);
            repeat (2) @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        fork responder(); join_none
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!hold_o && !ctl_oe_o && !ad_oe_o, "R3 reset releases bus", {31'b0, hold_o}, 32'd0);
        chk(rdy_out_n_o && rd_fifo_n_o && wr_fifo_n_o, "R7 reset strobes idle",
            {29'b0, rdy_out_n_o, rd_fifo_n_o, wr_fifo_n_o}, 32'd7);

        // R1: count resets to zero, address write alone starts nothing
        cpu_cycle(2'b10, 32'h0000_1000, 1'b1);
        expect_quiet("R1 reset count, address write only");
        // R10: read of count register is acknowledged but does not start
        cpu_cycle(2'b11, 32'h0000_0040, 1'b0);
        expect_quiet("R10 count read does not start");
        // R10: cycles outside register space get no acknowledge
        cpu_cycle(2'b01, 32'h0000_0040, 1'b1);
        expect_quiet("R10 A21=0 write ignored");

        run_xfer(32'h0000_2000, 24'd0, 1'b1);            // R1 zero count
        run_xfer(32'h0000_3000, 24'h000004, 1'b0);      // single word
        run_xfer(32'h0000_4003, 24'h000013, 1'b1);      // R1 low bits ignored
        run_xfer(32'h0000_5000, 24'h000014, 1'b0);      // 5 words
        run_xfer(32'h0000_6000, 24'h000020, 1'b1);      // 8 words

        for (int t = 0; t < 12; t++) begin
            logic [31:0] s;
            s = $urandom;
            run_xfer(s, 24'((1 + $urandom % 24) * 4), 1'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule